// File: doc/BRIEF.md
# Periodic State Leak Sweeper

This block drains a shared two-dimensional array of signed neuron states toward zero at a fixed rate. A programmable period counter runs all the time. Each time it expires, it schedules a pass over every cell of the array. During a pass, each cell's magnitude drops by a programmable amount, and the block never pushes a value past zero. The leak depends only on time. It does not depend on how many events the convolution engine is processing.

The state array sits outside the block, behind one synchronous single-port memory port with a read latency of one cycle. The convolution engine and the sweep both need that port, and an internal arbiter always gives the engine priority. The engine's request channel carries a valid signal but no ready signal, because the engine is never back-pressured. A request that is valid in a cycle is performed on the memory port in that same cycle. Read data returns on the next cycle, marked by a valid strobe. The sweep works on one cell at a time as a read followed by a write-back. It stalls whenever the engine holds the port and then continues exactly where it stopped.

Top module: `leak_sweeper`

## Requirements
- R1: A period counter counts clock cycles and expires once every `cfg_period` cycles. Each expiry requests one pass. A pass visits cell addresses 0 to CELLS-1 in ascending order, doing one read and then one write-back per cell.
- R2: During a pass, a cell value v with v > `cfg_amount` is written back as v - `cfg_amount`. Values are DW-bit two's complement, and `cfg_amount` is an unsigned DW-1 bit magnitude.
- R3: During a pass, a cell value v with v < -`cfg_amount` is written back as v + `cfg_amount`.
- R4: A cell value whose magnitude is at most `cfg_amount` is written back as exactly zero, so no value changes sign.
- R5: In any cycle where `ce_valid` is high, the memory port carries the engine's address, write enable and write data in that same cycle. For an engine read, `ce_rvalid` rises one cycle later and `ce_rdata` then holds the value that was stored.
- R6: While the engine holds the port, the sweep waits and then resumes at the same address, with no cell skipped or visited twice. If the engine writes the cell that the sweep has read but not yet written back, the sweep reads that cell again, so the engine's write is not lost.
- R7: While `cfg_period` is zero, the counter never expires and no new pass starts.
- R8: An expiry that arrives while a pass is running is held in a single pending flag, and any further expiries during that pass merge into it. When no engine request is present, the deferred pass issues its first read two cycles after the previous pass's last write-back.
- R9: While reset is held, and after it, the memory port is idle and `ce_rvalid` is low until a pass or an engine request begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | PW | Cycles between expiries; zero disables the leak |
| cfg_amount | input | DW-1 | Magnitude removed from each cell per pass |
| ce_valid | input | 1 | Engine memory request, always served in the same cycle |
| ce_we | input | 1 | Engine request is a write |
| ce_addr | input | AW | Engine cell address |
| ce_wdata | input | DW | Engine write data |
| ce_rvalid | output | 1 | Engine read data valid (one cycle after the read) |
| ce_rdata | output | DW | Engine read data |
| mem_en | output | 1 | Memory port enable |
| mem_we | output | 1 | Memory port write enable |
| mem_addr | output | AW | Memory port address |
| mem_wdata | output | DW | Memory port write data |
| mem_rdata | input | DW | Memory read data, one cycle after the read |

## Verification
The bench builds the block with a 4 x 4 array of 8-bit states and an 8-bit period counter, so one pass takes about 32 cycles. It runs one period of 60, long enough for each pass to finish in isolation, and one period of 10, which expires several times inside every pass and so exercises the single pending flag and the two-cycle restart. Random engine traffic over so few cells often writes the very cell the sweep holds. This exposes the re-read path, as well as the clamp at zero and the most negative value.

// File: rtl/leak_pkg.sv
package leak_pkg;
  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_READ  = 2'd1,
    SW_WRITE = 2'd2
  } sweep_state_e;
endpackage

// File: rtl/leak_period_timer.sv
module leak_period_timer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period,
  output logic          tick
);
  logic [PW-1:0] cnt_q;

  // A shrinking period while counting still expires at once (>=).
  always_comb tick = (period != '0) && (cnt_q >= period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (period == '0 || tick)   cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/leak_sweep_fsm.sv
module leak_sweep_fsm
  import leak_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CELLS = 4096,
  localparam int AW   = $clog2(CELLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-2:0] amount,
  input  logic          gnt,
  input  logic          eng_wr,
  input  logic [AW-1:0] eng_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          req,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata
);
  localparam logic [AW-1:0] LAST = AW'(CELLS - 1);

  sweep_state_e  state_q;
  logic [AW-1:0] addr_q;
  logic          pend_q;
  logic          rd_pend_q;
  logic [DW-1:0] hold_q;
  logic [DW-1:0] cur;
  logic          stale;

  function automatic logic [DW-1:0] leak_step(input logic [DW-1:0] v,
                                              input logic [DW-2:0] a);
    logic signed [DW:0] vx, ax, r;
    vx = {v[DW-1], v};
    ax = {2'b00, a};
    if (vx > ax)       r = vx - ax;
    else if (vx < -ax) r = vx + ax;
    else               r = '0;
    return r[DW-1:0];
  endfunction

  always_comb begin
    cur   = rd_pend_q ? mem_rdata : hold_q;
    stale = (state_q == SW_WRITE) && eng_wr && (eng_addr == addr_q);
    req   = (state_q != SW_IDLE);
    we    = (state_q == SW_WRITE);
    addr  = addr_q;
    wdata = leak_step(cur, amount);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SW_IDLE;
      addr_q    <= '0;
      pend_q    <= 1'b0;
      rd_pend_q <= 1'b0;
      hold_q    <= '0;
    end else begin
      rd_pend_q <= (state_q == SW_READ) && gnt;
      if (rd_pend_q) hold_q <= mem_rdata;
      if (tick) pend_q <= 1'b1;
      else if (state_q == SW_IDLE && pend_q) pend_q <= 1'b0;
      case (state_q)
        SW_IDLE: if (pend_q) begin
          state_q <= SW_READ;
          addr_q  <= '0;
        end
        SW_READ: if (gnt) state_q <= SW_WRITE;
        SW_WRITE: begin
          if (stale) state_q <= SW_READ;
          else if (gnt) begin
            addr_q  <= addr_q + 1'b1;
            state_q <= (addr_q == LAST) ? SW_IDLE : SW_READ;
          end
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end

  // R4: a write-back is zero or keeps the sign of the value read.
  p_no_sign_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SW_WRITE && gnt) |-> (wdata == '0 || wdata[DW-1] == cur[DW-1]));
  // R6: a stalled sweep keeps its address.
  p_pause_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !gnt) |=> $stable(addr_q));
  // R8: expiry during a pass is remembered.
  p_defer_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && state_q != SW_IDLE) |=> pend_q);
  // R1: every pass starts at address zero.
  p_pass_from_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SW_IDLE && pend_q) |=> (state_q == SW_READ && addr_q == '0));
endmodule

// File: rtl/leak_port_arbiter.sv
module leak_port_arbiter #(
  parameter int DW = 8,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eng_valid,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [DW-1:0] eng_wdata,
  output logic          eng_rvalid,
  input  logic          sw_req,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_addr,
  input  logic [DW-1:0] sw_wdata,
  output logic          sw_gnt,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  always_comb begin
    sw_gnt = sw_req && !eng_valid;
    mem_en = eng_valid || sw_req;
    if (eng_valid) begin
      mem_we    = eng_we;
      mem_addr  = eng_addr;
      mem_wdata = eng_wdata;
    end else begin
      mem_we    = sw_req && sw_we;
      mem_addr  = sw_addr;
      mem_wdata = sw_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) eng_rvalid <= 1'b0;
    else        eng_rvalid <= eng_valid && !eng_we;
  end
endmodule

// File: rtl/leak_sweeper.sv
module leak_sweeper #(
  parameter int ROWS  = 64,
  parameter int COLS  = 64,
  parameter int DW    = 8,
  parameter int PW    = 16,
  localparam int CELLS = ROWS * COLS,
  localparam int AW    = $clog2(CELLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] cfg_period,
  input  logic [DW-2:0] cfg_amount,
  input  logic          ce_valid,
  input  logic          ce_we,
  input  logic [AW-1:0] ce_addr,
  input  logic [DW-1:0] ce_wdata,
  output logic          ce_rvalid,
  output logic [DW-1:0] ce_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  logic          tick;
  logic          sw_req, sw_we, sw_gnt;
  logic [AW-1:0] sw_addr;
  logic [DW-1:0] sw_wdata;

  assign ce_rdata = mem_rdata;

  leak_period_timer #(.PW(PW)) u_timer (
    .clk(clk), .rst_n(rst_n), .period(cfg_period), .tick(tick));

  leak_sweep_fsm #(.DW(DW), .CELLS(CELLS)) u_sweep (
    .clk(clk), .rst_n(rst_n), .tick(tick), .amount(cfg_amount),
    .gnt(sw_gnt), .eng_wr(ce_valid && ce_we), .eng_addr(ce_addr),
    .mem_rdata(mem_rdata), .req(sw_req), .we(sw_we), .addr(sw_addr),
    .wdata(sw_wdata));

  leak_port_arbiter #(.DW(DW), .AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .eng_valid(ce_valid), .eng_we(ce_we), .eng_addr(ce_addr),
    .eng_wdata(ce_wdata), .eng_rvalid(ce_rvalid),
    .sw_req(sw_req), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .sw_gnt(sw_gnt), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata));
endmodule

// File: tb/leak_sweeper_test.sv
module leak_sweeper_test;
  localparam int ROWS = 4, COLS = 4, DW = 8, PW = 8;
  localparam int CELLS = ROWS * COLS;
  localparam int AW = $clog2(CELLS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] cfg_period = '0;
  logic [DW-2:0] cfg_amount = '0;
  logic          ce_valid = 1'b0, ce_we = 1'b0;
  logic [AW-1:0] ce_addr = '0;
  logic [DW-1:0] ce_wdata = '0;
  logic          ce_rvalid;
  logic [DW-1:0] ce_rdata;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  logic          load_en = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [DW-1:0] load_data = '0;
  logic [DW-1:0] ram [CELLS];

  int shadow [CELLS];
  int checks = 0, errors = 0;
  int cyc = 0, passes = 0, last_end = 0, next_addr = 0, sweep_acc = 0;
  bit exp_rv = 1'b0, gap_mode = 1'b0, done = 1'b0;
  int exp_rd = 0;

  always #4 clk = ~clk;

  leak_sweeper #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_amount(cfg_amount),
    .ce_valid(ce_valid), .ce_we(ce_we), .ce_addr(ce_addr), .ce_wdata(ce_wdata),
    .ce_rvalid(ce_rvalid), .ce_rdata(ce_rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (load_en) ram[load_addr] <= load_data;
    else if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      mem_rdata <= ram[mem_addr];
    end
  end

  function automatic int sx(input logic [DW-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int leak_ref(input int v, input int a);
    if (v > a) return v - a;
    if (v < -a) return v + a;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle reference comparison.
  always @(negedge clk) begin
    if (!rst_n) begin
      if (!load_en) begin
        chk("R9 mem_en in reset", int'(mem_en), 0);
        chk("R9 ce_rvalid in reset", int'(ce_rvalid), 0);
      end
    end else if (!done) begin
      cyc++;
      chk("R5 read data strobe", int'(ce_rvalid), int'(exp_rv));
      if (exp_rv) chk("R5 read data", sx(ce_rdata), exp_rd);
      exp_rv = 1'b0;
      if (ce_valid) begin
        chk("R5 port enable", int'(mem_en), 1);
        chk("R5 port we", int'(mem_we), int'(ce_we));
        chk("R5 port addr", int'(mem_addr), int'(ce_addr));
        if (ce_we) begin
          chk("R5 port wdata", int'(mem_wdata), int'(ce_wdata));
          shadow[ce_addr] = sx(ce_wdata);
        end else begin
          exp_rv = 1'b1;
          exp_rd = shadow[ce_addr];
        end
      end else if (mem_en) begin
        sweep_acc++;
        chk("R6 sweep address order", int'(mem_addr), next_addr);
        if (mem_we) begin
          // R2 R3 R4: write-back value from the reference leak
          chk("R2/R3/R4 leak value", sx(mem_wdata),
              leak_ref(shadow[mem_addr], int'(cfg_amount)));
          shadow[mem_addr] = sx(mem_wdata);
          if (int'(mem_addr) == CELLS - 1) begin
            passes++;
            last_end = cyc;
            next_addr = 0;
          end else next_addr = int'(mem_addr) + 1;
        end else if (gap_mode && mem_addr == '0)
          chk("R8 restart gap", cyc - last_end, 2);
      end
    end
  end

  task automatic drive(input bit v, input bit w, input int a, input int d);
    @(posedge clk); #1;
    ce_valid = v; ce_we = w; ce_addr = AW'(a); ce_wdata = DW'(d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p0, a0;
    int init_v [CELLS];
    for (int i = 0; i < CELLS; i++) init_v[i] = (i % 2 == 0) ? 20 : -20;
    init_v[0] = 3;  init_v[1] = -5;  init_v[2] = 7;  init_v[3] = -128;
    init_v[4] = 127; init_v[5] = 0;  init_v[6] = 9;  init_v[7] = -9;
    cfg_period = 8'd60;
    cfg_amount = 7'd2;
    for (int i = 0; i < CELLS; i++) begin
      @(posedge clk); #1;
      load_en = 1'b1; load_addr = AW'(i); load_data = DW'(init_v[i]);
      shadow[i] = init_v[i];
    end
    @(posedge clk); #1 load_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: four expiries of a 60-cycle period in 290 cycles
    repeat (290) @(posedge clk);
    @(negedge clk);
    chk("R1 passes in window", passes, 4);
    chk("R4 clamp positive", sx(ram[0]), 0);
    chk("R4 clamp negative", sx(ram[1]), 0);
    chk("R4 clamp after steps", sx(ram[2]), 0);
    chk("R3 most negative", sx(ram[3]), -120);
    chk("R2 most positive", sx(ram[4]), 119);
    chk("R2 small positive", sx(ram[6]), 1);
    chk("R3 small negative", sx(ram[7]), -1);

    // R5 R6: random engine traffic over a running leak
    cfg_amount = 7'd5;
    p0 = passes;
    for (int k = 0; k < 600; k++)
      drive(($urandom % 10) < 4, $urandom % 2, $urandom % CELLS, $urandom % 256);
    drive(0, 0, 0, 0);
    @(negedge clk);
    checks++;
    if (passes - p0 < 5) begin
      errors++;
      $display("FAIL R6 passes under traffic actual %0d expected >=5", passes - p0);
    end

    // R7: zero period stops new passes
    cfg_period = '0;
    repeat (80) @(posedge clk);
    p0 = passes; a0 = sweep_acc;
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk("R7 no pass while disabled", passes, p0);
    chk("R7 no sweep access while disabled", sweep_acc, a0);

    // R8: period shorter than a pass
    cfg_period = 8'd10;
    cfg_amount = 7'd1;
    p0 = passes;
    wait (passes > p0);
    gap_mode = 1'b1;
    p0 = passes;
    repeat (400) @(posedge clk);
    @(negedge clk);
    gap_mode = 1'b0;
    checks++;
    if (passes - p0 < 10 || passes - p0 > 13) begin
      errors++;
      $display("FAIL R8 deferred pass count actual %0d expected 10..13", passes - p0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule